// File: doc/BRIEF.md
# Multi-CPU Interrupt Distribution Unit

This block is the shared interrupt controller of a small multiprocessor. It holds a set of common interrupt lines. Each line has its own target-CPU bitmask, destination mode and trigger mode, and it routes raised lines to per-CPU interrupt outputs. Software reaches it through two words. The command word packs an opcode in bits 7:0 with a line number in bits 15:8. The parameter word supplies data for write commands and returns the results of read commands.

A line can deliver to one CPU of its mask chosen in rotation, to the lowest-numbered CPU of its mask, or to every CPU of its mask. Pulse-triggered lines interrupt for a single clock. Level-triggered lines hold until software clears them. A CPU signals that it has taken an interrupt on its take input, and software can read back per-CPU pending and acknowledge bitmasks. Common line n appears on output bit `c*NUM_LINES+n` for CPU c. Each CPU wires that bit to its private interrupt input 16+n, so a line whose mask holds only CPU n acts as an inter-processor interrupt. Software configures the lines while the unit is globally disabled and then enables it.

Top module: `irq_dist_unit`

## Requirements
- R1: After reset the unit is disabled, every line has mask 0, destination mode 0 (off), level trigger and rotation pointer 0, the parameter word reads 0 and all `cpu_irq` bits are 0.
- R2: Opcode 0x01 enables the unit and opcode 0x00 disables it, whatever the line field holds. A raise command (0x03) issued while the unit is disabled delivers nothing. While the unit is disabled every `cpu_irq` bit is 0, and pending state that is already held reappears on re-enable.
- R3: Opcode 0x09 stores parameter bits NUM_CPUS-1:0 as the line's target mask. Opcode 0x0A returns that mask in parameter bits NUM_CPUS-1:0, with all other bits 0.
- R4: Opcode 0x04 stores parameter bits 1:0 as the destination mode (0 off, 1 rotation, 2 first, 3 all) and parameter bit 15 as the trigger (0 level, 1 pulse). Opcode 0x08 returns them in the same positions. Every read command places its result in the parameter word at the clock edge that accepts the command. The result has priority over a parameter write in that same cycle. The parameter word otherwise holds its value.
- R5: In rotation mode each raise delivers to the first mask bit at or after the line's pointer, searching circularly. The pointer then moves to the next set mask bit after the one that received the interrupt. Opcode 0x05 returns the pointer in bits 15:8 and, in bit 0, a 1 when the destination mode is not off.
- R6: In first mode a raise delivers only to the lowest-numbered CPU in the mask.
- R7: In all mode a raise delivers to every CPU in the mask. In off mode, or with an empty mask, a raise delivers nothing.
- R8: A delivery replaces the line's pending bitmask. A pulse-triggered line's pending bits last exactly one clock. A level-triggered line's bits persist until a clear command (0x02).
- R9: A CPU that asserts its take bit for a line while its pending bit is visible gets its acknowledge bit set. Opcode 0x06 returns the acknowledge bitmask. Opcode 0x07 returns the pending bits that are not yet acknowledged. Clear zeroes both.
- R10: A command whose opcode is above 0x0A, or a line command whose line number is NUM_LINES or more, changes no configuration, no enable state and no parameter word.
- R11: Output bit `c*NUM_LINES+n` of `cpu_irq` carries line n's pending bit for CPU c. Input bit `c*NUM_LINES+n` of `cpu_take` is CPU c's take for line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | DATA_W | Command word: line in 15:8, opcode in 7:0 |
| par_we | input | 1 | Parameter word write strobe |
| par_wdata | input | DATA_W | Parameter word write data |
| par_rdata | output | DATA_W | Parameter word contents, including read results |
| cpu_take | input | NUM_CPUS*NUM_LINES | Per-CPU, per-line interrupt-taken indication |
| cpu_irq | output | NUM_CPUS*NUM_LINES | Per-CPU, per-line interrupt outputs |

## Verification
The assertions check on every cycle that a rotation or first-mode delivery leaves at most one CPU pending and that a pulse line's pending bits are gone one clock later. They also check that an acknowledge bit only appears where a pending bit was visible, that the rotation pointer lands on a mask bit, and that ignored commands leave configuration, enable state and the parameter word untouched. Only the directed scenarios can show the exact rotation order over several raises, the gating by global enable, the read-back encodings, and the exact output bit each line and CPU uses.

// File: rtl/irq_dist_pkg.sv
// Package: shared opcode and destination-mode encodings for the
// interrupt distribution unit. Assumes an 8-bit opcode field.
package irq_dist_pkg;

    typedef enum logic [7:0] {
        OP_GDIS   = 8'h00,
        OP_GEN    = 8'h01,
        OP_CLR    = 8'h02,
        OP_RAISE  = 8'h03,
        OP_WMODE  = 8'h04,
        OP_RSTAT  = 8'h05,
        OP_RACK   = 8'h06,
        OP_RPEND  = 8'h07,
        OP_RMODE  = 8'h08,
        OP_WMASK  = 8'h09,
        OP_RMASK  = 8'h0A
    } op_e;

    localparam logic [7:0] OP_LAST = 8'h0A;

    typedef enum logic [1:0] {
        DST_OFF   = 2'd0,
        DST_RR    = 2'd1,
        DST_FIRST = 2'd2,
        DST_ALL   = 2'd3
    } dst_e;

endpackage

// File: rtl/idu_cmd_decode.sv
// Command decoder: turns a command-word write into single-cycle strobes.
// Assumes opcode in bits 7:0 and line number in bits 15:8. Drops unknown
// opcodes and line commands whose line number is out of range.
module idu_cmd_decode
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              g_en,
    output logic              g_dis,
    output logic              l_clr,
    output logic              l_raise,
    output logic              l_wmode,
    output logic              l_wmask,
    output logic              rd_valid,
    output logic [7:0]        rd_op,
    output logic [LINE_W-1:0] line_idx
);

    logic [7:0] opcode;
    logic [7:0] line_fld;
    logic       in_range;

    assign opcode   = cmd_word[7:0];
    assign line_fld = cmd_word[15:8];
    assign in_range = (int'(line_fld) < NUM_LINES);
    assign line_idx = line_fld[LINE_W-1:0];
    assign rd_op    = opcode;

    // Decode the opcode into one strobe, gated by range checks.
    always_comb begin
        g_en     = 1'b0;
        g_dis    = 1'b0;
        l_clr    = 1'b0;
        l_raise  = 1'b0;
        l_wmode  = 1'b0;
        l_wmask  = 1'b0;
        rd_valid = 1'b0;
        if (cmd_we && opcode <= OP_LAST) begin
            if (opcode == OP_GEN)       g_en  = 1'b1;
            else if (opcode == OP_GDIS) g_dis = 1'b1;
            else if (in_range) begin
                case (opcode)
                    OP_CLR:   l_clr    = 1'b1;
                    OP_RAISE: l_raise  = 1'b1;
                    OP_WMODE: l_wmode  = 1'b1;
                    OP_WMASK: l_wmask  = 1'b1;
                    default:  rd_valid = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/idu_pick.sv
// Circular priority picker: finds the first set bit of a mask at or after
// a start index, wrapping around. Assumes start < N.
module idu_pick #(
    parameter int N   = 4,
    localparam int W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] idx
);

    int pos;

    // Scan N positions from start, keep the first hit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int k = 0; k < N; k++) begin
            pos = (int'(start) + k) % N;
            if (!found && mask[pos]) begin
                found = 1'b1;
                idx   = W'(pos);
            end
        end
    end

endmodule

// File: rtl/idu_line.sv
// One common interrupt line: configuration, recipient selection, rotation
// pointer, per-CPU pending and acknowledge state. Assumes at most one
// strobe per cycle from the decoder.
module idu_line
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int DATA_W   = 32,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                clr,
    input  logic                raise,
    input  logic                wmode,
    input  logic                wmask,
    input  logic [DATA_W-1:0]   par,
    input  logic [NUM_CPUS-1:0] take,
    output logic [NUM_CPUS-1:0] pend,
    output logic [NUM_CPUS-1:0] ack,
    output logic [NUM_CPUS-1:0] mask,
    output logic [1:0]          dmode,
    output logic                trig,
    output logic [CPU_W-1:0]    ptr
);

    logic               rr_found, rr_nfound, fst_found;
    logic [CPU_W-1:0]   rr_idx, rr_nidx, fst_idx, after_rr;
    logic [NUM_CPUS-1:0] rcpt;
    logic               deliver;

    assign after_rr = CPU_W'((int'(rr_idx) + 1) % NUM_CPUS);

    idu_pick #(.N(NUM_CPUS)) u_pick_rr (
        .mask(mask), .start(ptr), .found(rr_found), .idx(rr_idx));
    idu_pick #(.N(NUM_CPUS)) u_pick_next (
        .mask(mask), .start(after_rr), .found(rr_nfound), .idx(rr_nidx));
    idu_pick #(.N(NUM_CPUS)) u_pick_first (
        .mask(mask), .start('0), .found(fst_found), .idx(fst_idx));

    // Recipient set for a raise under the current destination mode.
    always_comb begin
        rcpt = '0;
        case (dst_e'(dmode))
            DST_RR:    if (rr_found)  rcpt[rr_idx]  = 1'b1;
            DST_FIRST: if (fst_found) rcpt[fst_idx] = 1'b1;
            DST_ALL:   rcpt = mask;
            default:   rcpt = '0;
        endcase
    end

    assign deliver = raise && en && (|rcpt);

    // Configuration, pending, acknowledge and pointer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            dmode <= DST_OFF;
            trig  <= 1'b0;
            ptr   <= '0;
            pend  <= '0;
            ack   <= '0;
        end else begin
            if (wmask) mask <= par[NUM_CPUS-1:0];
            if (wmode) begin
                dmode <= par[1:0];
                trig  <= par[15];
            end
            if (clr) begin
                pend <= '0;
                ack  <= '0;
            end else begin
                if (deliver)   pend <= rcpt;
                else if (trig) pend <= '0;
                ack <= ack | (take & pend & {NUM_CPUS{en}});
            end
            if (deliver && dst_e'(dmode) == DST_RR && rr_nfound) ptr <= rr_nidx;
        end
    end

    // R5/R6: a rotation or first delivery leaves at most one CPU pending
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        deliver && dst_e'(dmode) != DST_ALL |=> $onehot0(pend));

    // R8: pulse-triggered pending bits are gone one clock later
    p_pulse_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig && !deliver |=> pend == '0);

    // R9: an acknowledge bit only rises where a pending bit was held
    p_ack_from_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~$past(ack)) & ~$past(pend)) == '0);

    // R5: after a rotation delivery the pointer lands on a mask bit
    p_ptr_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deliver && dst_e'(dmode) == DST_RR |=> mask[ptr]);

endmodule

// File: rtl/irq_dist_unit.sv
// Interrupt distribution unit top: decodes command-word writes, holds the
// parameter word, instantiates one state slice per common line and maps
// line/CPU pending state to the flat interrupt outputs. Assumes software
// issues at most one command per cycle.
module irq_dist_unit
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CPUS  = 4,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int FLAT_W   = NUM_CPUS * NUM_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              par_we,
    input  logic [DATA_W-1:0] par_wdata,
    output logic [DATA_W-1:0] par_rdata,
    input  logic [FLAT_W-1:0] cpu_take,
    output logic [FLAT_W-1:0] cpu_irq
);

    logic              g_en, g_dis, l_clr, l_raise, l_wmode, l_wmask, rd_valid;
    logic [7:0]        rd_op;
    logic [LINE_W-1:0] line_idx;
    logic              en_q;
    logic [DATA_W-1:0] par_q;
    logic [DATA_W-1:0] rd_res;

    logic [NUM_CPUS-1:0] pend_a [NUM_LINES];
    logic [NUM_CPUS-1:0] ack_a  [NUM_LINES];
    logic [NUM_CPUS-1:0] mask_a [NUM_LINES];
    logic [1:0]          dmode_a[NUM_LINES];
    logic                trig_a [NUM_LINES];
    logic [CPU_W-1:0]    ptr_a  [NUM_LINES];
    logic [FLAT_W-1:0]   mask_flat;
    logic [3*NUM_LINES-1:0] mode_flat;

    idu_cmd_decode #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dec (
        .cmd_we(cmd_we), .cmd_word(cmd_wdata),
        .g_en(g_en), .g_dis(g_dis), .l_clr(l_clr), .l_raise(l_raise),
        .l_wmode(l_wmode), .l_wmask(l_wmask), .rd_valid(rd_valid),
        .rd_op(rd_op), .line_idx(line_idx));

    // Global enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (g_en)  en_q <= 1'b1;
        else if (g_dis) en_q <= 1'b0;
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic                sel;
        logic [NUM_CPUS-1:0] take_l;
        assign sel = (line_idx == LINE_W'(l));
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            assign take_l[c]               = cpu_take[c*NUM_LINES+l];
            assign cpu_irq[c*NUM_LINES+l]  = pend_a[l][c] & en_q;
            assign mask_flat[l*NUM_CPUS+c] = mask_a[l][c];
        end
        assign mode_flat[3*l +: 3] = {trig_a[l], dmode_a[l]};

        idu_line #(.NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W)) u_line (
            .clk(clk), .rst_n(rst_n), .en(en_q),
            .clr(l_clr && sel), .raise(l_raise && sel),
            .wmode(l_wmode && sel), .wmask(l_wmask && sel),
            .par(par_q), .take(take_l),
            .pend(pend_a[l]), .ack(ack_a[l]), .mask(mask_a[l]),
            .dmode(dmode_a[l]), .trig(trig_a[l]), .ptr(ptr_a[l]));
    end

    // Read-result multiplexer for the addressed line.
    always_comb begin
        rd_res = '0;
        case (rd_op)
            OP_RSTAT: begin
                rd_res[8 +: CPU_W] = ptr_a[line_idx];
                rd_res[0]          = (dmode_a[line_idx] != DST_OFF);
            end
            OP_RACK:  rd_res[NUM_CPUS-1:0] = ack_a[line_idx];
            OP_RPEND: rd_res[NUM_CPUS-1:0] = pend_a[line_idx] & ~ack_a[line_idx];
            OP_RMODE: begin
                rd_res[15]  = trig_a[line_idx];
                rd_res[1:0] = dmode_a[line_idx];
            end
            OP_RMASK: rd_res[NUM_CPUS-1:0] = mask_a[line_idx];
            default:  rd_res = '0;
        endcase
    end

    // Parameter word: read results take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        par_q <= '0;
        else if (rd_valid) par_q <= rd_res;
        else if (par_we)   par_q <= par_wdata;
    end

    assign par_rdata = par_q;

    // R10: unknown opcodes and out-of-range line commands change nothing
    p_ignored_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !par_we && (cmd_wdata[7:0] > OP_LAST ||
            (cmd_wdata[7:0] > OP_GEN && int'(cmd_wdata[15:8]) >= NUM_LINES))
        |=> $stable(mask_flat) && $stable(mode_flat) && $stable(en_q)
            && $stable(par_q));

    // R4: without any write the parameter word holds its value
    p_par_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we && !par_we |=> $stable(par_rdata));

endmodule

// File: tb/irq_dist_unit_tb.sv
module irq_dist_unit_tb;

    localparam int NL = 16;
    localparam int NC = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          par_we = 1'b0;
    logic [DW-1:0] par_wdata = '0;
    logic [DW-1:0] par_rdata;
    logic [NC*NL-1:0] cpu_take = '0;
    logic [NC*NL-1:0] cpu_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_dist_unit #(.NUM_LINES(NL), .NUM_CPUS(NC), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .par_we(par_we), .par_wdata(par_wdata), .par_rdata(par_rdata),
        .cpu_take(cpu_take), .cpu_irq(cpu_irq));

    function automatic logic [NC*NL-1:0] irq_vec(int line, logic [NC-1:0] cpus);
        logic [NC*NL-1:0] v = '0;
        for (int c = 0; c < NC; c++) if (cpus[c]) v[c*NL+line] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [NC*NL-1:0] act, logic [NC*NL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All drive tasks start and end on a falling edge.
    task automatic do_cmd(logic [7:0] op, logic [7:0] line);
        cmd_we    = 1'b1;
        cmd_wdata = {16'h0, line, op};
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    task automatic wr_par(logic [DW-1:0] v);
        par_we    = 1'b1;
        par_wdata = v;
        @(negedge clk);
        par_we    = 1'b0;
    endtask

    task automatic setup(int line, logic [NC-1:0] m, logic [1:0] dst, logic pulse);
        wr_par(DW'(m));
        do_cmd(8'h09, 8'(line));
        wr_par({16'h0, pulse, 13'h0, dst});
        do_cmd(8'h04, 8'(line));
    endtask

    task automatic t_reset;
        chk("R1 par after reset", 64'(par_rdata), 64'h0);
        chk("R1 irq after reset", cpu_irq, '0);
        do_cmd(8'h08, 8'd0);
        chk("R1 mode after reset", 64'(par_rdata), 64'h0);
        do_cmd(8'h05, 8'd3);
        chk("R1 status after reset", 64'(par_rdata), 64'h0);
    endtask

    task automatic t_cfg;
        wr_par(32'hFFFF_FFFB);
        do_cmd(8'h09, 8'd2);
        do_cmd(8'h0A, 8'd2);
        chk("R3 mask readback", 64'(par_rdata), 64'hB);
        wr_par(32'h0000_8002);
        do_cmd(8'h04, 8'd2);
        do_cmd(8'h08, 8'd2);
        chk("R4 mode readback", 64'(par_rdata), 64'h8002);
        do_cmd(8'h0A, 8'd3);
        chk("R3 other line untouched", 64'(par_rdata), 64'h0);
        par_we = 1'b1; par_wdata = 32'h1234;
        cmd_we = 1'b1; cmd_wdata = {16'h0, 8'd2, 8'h0A};
        @(negedge clk);
        par_we = 1'b0; cmd_we = 1'b0;
        chk("R4 read result beats param write", 64'(par_rdata), 64'hB);
    endtask

    task automatic t_enable;
        setup(1, 4'b0010, 2'd3, 1'b0);
        do_cmd(8'h03, 8'd1);
        chk("R2 raise while disabled", cpu_irq, '0);
        do_cmd(8'h07, 8'd1);
        chk("R2 no pending while disabled", 64'(par_rdata), 64'h0);
        do_cmd(8'h01, 8'd77);
        do_cmd(8'h03, 8'd1);
        chk("R2 R11 raise while enabled", cpu_irq, irq_vec(1, 4'b0010));
        do_cmd(8'h00, 8'd0);
        chk("R2 outputs gated when disabled", cpu_irq, '0);
        do_cmd(8'h01, 8'd0);
        chk("R2 pending back on re-enable", cpu_irq, irq_vec(1, 4'b0010));
        do_cmd(8'h02, 8'd1);
        chk("R8 clear drops level line", cpu_irq, '0);
    endtask

    task automatic t_all_level;
        setup(5, 4'b1111, 2'd3, 1'b0);
        do_cmd(8'h03, 8'd5);
        chk("R7 R11 all recipients", cpu_irq, irq_vec(5, 4'b1111));
        repeat (3) @(negedge clk);
        chk("R8 level holds", cpu_irq, irq_vec(5, 4'b1111));
        do_cmd(8'h07, 8'd5);
        chk("R9 pending readback", 64'(par_rdata), 64'hF);
        do_cmd(8'h02, 8'd5);
        setup(6, 4'b1111, 2'd0, 1'b0);
        do_cmd(8'h03, 8'd6);
        chk("R7 off mode delivers nothing", cpu_irq, '0);
        setup(4, 4'b0000, 2'd3, 1'b0);
        do_cmd(8'h03, 8'd4);
        chk("R7 empty mask delivers nothing", cpu_irq, '0);
    endtask

    task automatic t_first;
        setup(7, 4'b1100, 2'd2, 1'b0);
        do_cmd(8'h03, 8'd7);
        chk("R6 lowest mask cpu only", cpu_irq, irq_vec(7, 4'b0100));
        do_cmd(8'h02, 8'd7);
    endtask

    task automatic t_rr;
        logic [NC-1:0] order [3] = '{4'b0001, 4'b0010, 4'b1000};
        logic [31:0]   ptrs  [3] = '{32'h0101, 32'h0301, 32'h0001};
        setup(8, 4'b1011, 2'd1, 1'b1);
        do_cmd(8'h05, 8'd8);
        chk("R5 status before rotation", 64'(par_rdata), 64'h0001);
        for (int i = 0; i < 3; i++) begin
            do_cmd(8'h03, 8'd8);
            chk("R5 rotation recipient", cpu_irq, irq_vec(8, order[i]));
            @(negedge clk);
            chk("R8 pulse lasts one clock", cpu_irq, '0);
            do_cmd(8'h05, 8'd8);
            chk("R5 pointer in status", 64'(par_rdata), 64'(ptrs[i]));
        end
    endtask

    task automatic t_ack;
        setup(9, 4'b0110, 2'd3, 1'b0);
        do_cmd(8'h03, 8'd9);
        cpu_take[1*NL+9] = 1'b1;
        cpu_take[3*NL+9] = 1'b1;
        @(negedge clk);
        cpu_take = '0;
        do_cmd(8'h06, 8'd9);
        chk("R9 ack only for pending cpu", 64'(par_rdata), 64'h2);
        do_cmd(8'h07, 8'd9);
        chk("R9 pending excludes acked", 64'(par_rdata), 64'h4);
        chk("R9 level stays after take", cpu_irq, irq_vec(9, 4'b0110));
        do_cmd(8'h02, 8'd9);
        do_cmd(8'h06, 8'd9);
        chk("R9 clear zeroes ack", 64'(par_rdata), 64'h0);
        chk("R9 clear drops outputs", cpu_irq, '0);
    endtask

    task automatic t_ignore;
        wr_par(32'h0000_000F);
        do_cmd(8'h09, 8'd16);
        do_cmd(8'h0A, 8'd0);
        chk("R10 out-of-range line ignored", 64'(par_rdata), 64'h0);
        wr_par(32'h0000_00A5);
        do_cmd(8'h0B, 8'd0);
        chk("R10 unknown opcode keeps param", 64'(par_rdata), 64'hA5);
        do_cmd(8'h0A, 8'd200);
        chk("R10 out-of-range read keeps param", 64'(par_rdata), 64'hA5);
        do_cmd(8'h03, 8'd21);
        chk("R10 out-of-range raise no output", cpu_irq, '0);
        do_cmd(8'h0A, 8'd0);
        chk("R10 line 0 mask unchanged", 64'(par_rdata), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_enable();
        t_all_level();
        t_first();
        t_rr();
        t_ack();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule